// File: doc/BRIEF.md
# TCP/UDP Header Sanity Checker

This block watches the layer-4 part of a packet that an upstream parser has already split into IPv4 or IPv6 fields. Bytes arrive one per beat, with start and end of packet markers. On the first beat the parser also supplies the byte offset where the TCP or UDP header begins, the L4 length that the IP header declares, and whether the transport is TCP. On the last beat a separate checksum unit reports whether the TCP/UDP checksum matched.

While the packet streams through, the block collects the port numbers, the UDP length field and the TCP flag byte, and it counts how many bytes lie at or past the L4 offset. On the last beat it reduces every detected fault to one 4-bit code and presents it for a single cycle. When several faults are present, the lowest nonzero code is reported. A downstream unit uses the code to mark or drop the packet.

Top module: `l4_hdr_checker`

## Requirements
- R1: After reset, and in every cycle where `err_valid` is low, `err_valid` is 0 and `err_code` is 0.
- R2: An accepted beat with `in_eop` high produces `err_valid` high for exactly the following cycle, together with its code. A packet with no fault gives code 0. Idle cycles (valid low) inside a packet do not change the result.
- R3: Code 1 is reported when fewer bytes lie at or past the L4 offset than a full header needs: 20 for TCP, 8 for UDP.
- R4: Code 2 is reported when `csum_ok` is low on the end-of-packet beat.
- R5: Code 3 is reported when the lengths disagree. For TCP, the count of bytes from the L4 offset to the end of the packet differs from `l4_len`. For UDP, the big-endian length field at L4 bytes 4 and 5 differs from `l4_len`.
- R6: Code 4 is reported when the source port (L4 bytes 0 and 1, big-endian) or the destination port (L4 bytes 2 and 3) is zero.
- R7: For TCP, the flag byte is L4 byte 13, with FIN at bit 0, SYN at bit 1, RST at bit 2 and URG at bit 5. A flag byte of exactly 0x01 gives code 8, and a flag byte of 0x00 gives code 9.
- R8: For TCP, regardless of any other flag bits: FIN with RST gives 10, SYN with URG gives 11, SYN with RST gives 12, and SYN with FIN gives 13. A flag byte that matches none of these, such as 0x11, gives 0.
- R9: When several conditions hold, the smallest nonzero code is reported. A malformed header (code 1) therefore hides every port, length and flag fault. Only the codes 0 to 4 and 8 to 13 ever appear.
- R10: For UDP, L4 byte 13 is not examined, and only codes 0 to 4 can be reported.
- R11: `l4_offset`, `l4_len` and `is_tcp` are taken only on the start beat. `csum_ok` is taken only on the end beat. Valid beats that arrive outside a packet are ignored and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_sop | input | 1 | This beat is the first byte of a packet |
| in_eop | input | 1 | This beat is the last byte of a packet |
| in_byte | input | 8 | Packet byte |
| l4_offset | input | OFS_W | Byte index where the L4 header begins (start beat) |
| l4_len | input | LEN_W | L4 length declared by the IP header (start beat) |
| is_tcp | input | 1 | 1 for TCP, 0 for UDP (start beat) |
| csum_ok | input | 1 | Upstream checksum matched (end beat) |
| err_valid | output | 1 | One-cycle strobe after the end beat |
| err_code | output | 4 | Resolved error code, 0 when no strobe |

## Verification
Two things can land in the same cycle. One is the end-of-packet resolution of one packet. The other is the capture of the next packet's start beat, or in a one-byte packet the start and end on a single beat. The bench streams a packet and begins the next one on the very next cycle. It checks that the first strobe carries the first packet's code and that the second packet's code depends only on its own bytes and sideband values. It also builds packets that carry a checksum fault, a length fault, a zero port and an illegal flag byte all at once, and checks that only the lowest code is reported.

// File: rtl/l4chk_pkg.sv
package l4chk_pkg;

  typedef enum logic [3:0] {
    CODE_OK       = 4'd0,
    CODE_SHORT    = 4'd1,
    CODE_CSUM     = 4'd2,
    CODE_LEN      = 4'd3,
    CODE_PORT     = 4'd4,
    CODE_FIN_ONLY = 4'd8,
    CODE_NO_FLAGS = 4'd9,
    CODE_FIN_RST  = 4'd10,
    CODE_SYN_URG  = 4'd11,
    CODE_SYN_RST  = 4'd12,
    CODE_SYN_FIN  = 4'd13
  } l4_code_e;

  localparam int unsigned TCP_HDR_BYTES = 20;
  localparam int unsigned UDP_HDR_BYTES = 8;
  localparam int unsigned TCP_FLAG_POS  = 13;

  localparam int unsigned FIN_BIT = 0;
  localparam int unsigned SYN_BIT = 1;
  localparam int unsigned RST_BIT = 2;
  localparam int unsigned URG_BIT = 5;

  // header fields gathered while the packet streams through
  typedef struct packed {
    logic [15:0] src_port;
    logic [15:0] dst_port;
    logic [15:0] udp_len;
    logic [7:0]  flags;
  } l4_fields_t;

endpackage

// File: rtl/l4_byte_tracker.sv
module l4_byte_tracker
  import l4chk_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_byte,
  input  logic [OFS_W-1:0] l4_offset,
  input  logic [LEN_W-1:0] l4_len,
  input  logic             is_tcp,
  output logic             eop_take,
  output l4_fields_t       fld_nx,
  output logic [CNT_W-1:0] l4_cnt_nx,
  output logic [LEN_W-1:0] len_cur,
  output logic             tcp_cur
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LI_SRC_H = CNT_W'(0);
  localparam logic [CNT_W-1:0] LI_SRC_L = CNT_W'(1);
  localparam logic [CNT_W-1:0] LI_DST_H = CNT_W'(2);
  localparam logic [CNT_W-1:0] LI_DST_L = CNT_W'(3);
  localparam logic [CNT_W-1:0] LI_LEN_H = CNT_W'(4);
  localparam logic [CNT_W-1:0] LI_LEN_L = CNT_W'(5);
  localparam logic [CNT_W-1:0] LI_FLAGS = CNT_W'(TCP_FLAG_POS);

  logic             in_pkt_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] l4cnt_q;
  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] len_q;
  logic             tcp_q;
  l4_fields_t       fld_q;

  logic             take;
  logic             in_l4;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] li;
  logic [CNT_W-1:0] ofs_ext;
  logic [CNT_W-1:0] cnt_base;
  l4_fields_t       fld_base;

  always_comb begin
    take     = in_valid && (in_sop || in_pkt_q);
    idx      = in_sop ? '0 : pos_q;
    ofs_ext  = CNT_W'(in_sop ? l4_offset : ofs_q);
    in_l4    = take && (idx >= ofs_ext);
    li       = idx - ofs_ext;
    cnt_base = in_sop ? '0 : l4cnt_q;
    fld_base = in_sop ? '0 : fld_q;
    len_cur  = in_sop ? l4_len : len_q;
    tcp_cur  = in_sop ? is_tcp : tcp_q;
    eop_take = take && in_eop;

    fld_nx = fld_base;
    if (in_l4) begin
      case (li)
        LI_SRC_H: fld_nx.src_port[15:8] = in_byte;
        LI_SRC_L: fld_nx.src_port[7:0]  = in_byte;
        LI_DST_H: fld_nx.dst_port[15:8] = in_byte;
        LI_DST_L: fld_nx.dst_port[7:0]  = in_byte;
        LI_LEN_H: fld_nx.udp_len[15:8]  = in_byte;
        LI_LEN_L: fld_nx.udp_len[7:0]   = in_byte;
        LI_FLAGS: fld_nx.flags          = in_byte;
        default:  ;
      endcase
    end

    l4_cnt_nx = (in_l4 && cnt_base != CNT_MAX) ? cnt_base + CNT_W'(1) : cnt_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      pos_q    <= '0;
      l4cnt_q  <= '0;
      ofs_q    <= '0;
      len_q    <= '0;
      tcp_q    <= 1'b0;
      fld_q    <= '0;
    end else if (take) begin
      in_pkt_q <= !in_eop;
      pos_q    <= (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
      l4cnt_q  <= l4_cnt_nx;
      fld_q    <= fld_nx;
      if (in_sop) begin
        ofs_q <= l4_offset;
        len_q <= l4_len;
        tcp_q <= is_tcp;
      end
    end
  end

endmodule

// File: rtl/l4_flag_classifier.sv
module l4_flag_classifier
  import l4chk_pkg::*;
(
  input  logic [7:0] flags,
  output l4_code_e   code
);

  localparam logic [7:0] FIN_ALONE = 8'(1) << FIN_BIT;

  logic fin, syn, rst_f, urg;

  always_comb begin
    fin   = flags[FIN_BIT];
    syn   = flags[SYN_BIT];
    rst_f = flags[RST_BIT];
    urg   = flags[URG_BIT];
    if (flags == FIN_ALONE)   code = CODE_FIN_ONLY;
    else if (flags == 8'h00)  code = CODE_NO_FLAGS;
    else if (fin && rst_f)    code = CODE_FIN_RST;
    else if (syn && urg)      code = CODE_SYN_URG;
    else if (syn && rst_f)    code = CODE_SYN_RST;
    else if (syn && fin)      code = CODE_SYN_FIN;
    else                      code = CODE_OK;
  end

endmodule

// File: rtl/l4_code_resolver.sv
module l4_code_resolver
  import l4chk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] l4_cnt,
  input  logic [LEN_W-1:0] l4_len,
  input  logic             tcp,
  input  logic             csum_ok,
  input  l4_fields_t       fields,
  output l4_code_e         code
);

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] len_ext;
  logic [CNT_W-1:0] udp_ext;
  logic             short_hdr;
  logic             len_bad;
  logic             port_zero;
  l4_code_e         flag_code;

  l4_flag_classifier u_flags (
    .flags (fields.flags),
    .code  (flag_code)
  );

  always_comb begin
    need      = tcp ? CNT_W'(TCP_HDR_BYTES) : CNT_W'(UDP_HDR_BYTES);
    len_ext   = CNT_W'(l4_len);
    udp_ext   = CNT_W'(fields.udp_len);
    short_hdr = l4_cnt < need;
    len_bad   = tcp ? (l4_cnt != len_ext) : (udp_ext != len_ext);
    port_zero = (fields.src_port == 16'h0) || (fields.dst_port == 16'h0);

    if (short_hdr)      code = CODE_SHORT;
    else if (!csum_ok)  code = CODE_CSUM;
    else if (len_bad)   code = CODE_LEN;
    else if (port_zero) code = CODE_PORT;
    else if (tcp)       code = flag_code;
    else                code = CODE_OK;
  end

endmodule

// File: rtl/l4_hdr_checker.sv
module l4_hdr_checker
  import l4chk_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_byte,
  input  logic [OFS_W-1:0] l4_offset,
  input  logic [LEN_W-1:0] l4_len,
  input  logic             is_tcp,
  input  logic             csum_ok,
  output logic             err_valid,
  output logic [3:0]       err_code
);

  logic             eop_take;
  l4_fields_t       fld_nx;
  logic [CNT_W-1:0] l4_cnt_nx;
  logic [LEN_W-1:0] len_cur;
  logic             tcp_cur;
  l4_code_e         res_code;

  l4_byte_tracker #(
    .OFS_W (OFS_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_byte   (in_byte),
    .l4_offset (l4_offset),
    .l4_len    (l4_len),
    .is_tcp    (is_tcp),
    .eop_take  (eop_take),
    .fld_nx    (fld_nx),
    .l4_cnt_nx (l4_cnt_nx),
    .len_cur   (len_cur),
    .tcp_cur   (tcp_cur)
  );

  l4_code_resolver #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_resolve (
    .l4_cnt  (l4_cnt_nx),
    .l4_len  (len_cur),
    .tcp     (tcp_cur),
    .csum_ok (csum_ok),
    .fields  (fld_nx),
    .code    (res_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
    end else begin
      err_valid <= eop_take;
      err_code  <= eop_take ? 4'(res_code) : 4'(CODE_OK);
    end
  end

endmodule

// File: rtl/l4_hdr_checker_sva.sv
module l4_hdr_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic       in_eop,
  input logic       is_tcp,
  input logic       csum_ok,
  input logic       err_valid,
  input logic [3:0] err_code
);

  // transport type of the packet most recently started
  logic pkt_tcp;
  always_ff @(posedge clk) begin
    if (rst)                    pkt_tcp <= 1'b0;
    else if (in_valid && in_sop) pkt_tcp <= is_tcp;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!err_valid && err_code == 4'd0));

  assert_idle_code_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> err_code == 4'd0);

  assert_strobe_after_eop_R2: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(in_valid && in_eop));

  assert_csum_code_R4: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 4'd2) |-> $past(!csum_ok));

  assert_legal_code_R9: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code <= 4'd4 || (err_code >= 4'd8 && err_code <= 4'd13)));

  assert_udp_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !pkt_tcp) |-> err_code <= 4'd4);

endmodule

bind l4_hdr_checker l4_hdr_checker_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .in_eop    (in_eop),
  .is_tcp    (is_tcp),
  .csum_ok   (csum_ok),
  .err_valid (err_valid),
  .err_code  (err_code)
);

// File: tb/tb_l4_hdr_checker.sv
module tb_l4_hdr_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic [7:0]  in_byte = 8'h0;
  logic [7:0]  l4_offset = 8'h0;
  logic [15:0] l4_len = 16'h0;
  logic        is_tcp = 1'b0;
  logic        csum_ok = 1'b1;
  logic        err_valid;
  logic [3:0]  err_code;

  int total = 0;
  int bad = 0;

  logic [7:0] pkt [0:255];
  int         pkt_n;

  always #5 clk = ~clk;

  l4_hdr_checker dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_byte   (in_byte),
    .l4_offset (l4_offset),
    .l4_len    (l4_len),
    .is_tcp    (is_tcp),
    .csum_ok   (csum_ok),
    .err_valid (err_valid),
    .err_code  (err_code)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = 8'h0;
  endtask

  task automatic build_tcp(input int ofs, input int src, input int dst,
                           input logic [7:0] flags, input int pay);
    for (int i = 0; i < ofs; i++) pkt[i] = 8'hA5;
    pkt[ofs+0] = 8'(src >> 8); pkt[ofs+1] = 8'(src);
    pkt[ofs+2] = 8'(dst >> 8); pkt[ofs+3] = 8'(dst);
    for (int i = 4; i < 12; i++) pkt[ofs+i] = 8'h11;
    pkt[ofs+12] = 8'h50;
    pkt[ofs+13] = flags;
    for (int i = 14; i < 20; i++) pkt[ofs+i] = 8'h22;
    for (int i = 0; i < pay; i++) pkt[ofs+20+i] = 8'h33;
    pkt_n = ofs + 20 + pay;
  endtask

  task automatic build_udp(input int ofs, input int src, input int dst,
                           input int ulen, input int pay, input logic [7:0] fill);
    for (int i = 0; i < ofs; i++) pkt[i] = 8'h5A;
    pkt[ofs+0] = 8'(src >> 8);  pkt[ofs+1] = 8'(src);
    pkt[ofs+2] = 8'(dst >> 8);  pkt[ofs+3] = 8'(dst);
    pkt[ofs+4] = 8'(ulen >> 8); pkt[ofs+5] = 8'(ulen);
    pkt[ofs+6] = 8'h00;         pkt[ofs+7] = 8'h00;
    for (int i = 0; i < pay; i++) pkt[ofs+8+i] = fill;
    pkt_n = ofs + 8 + pay;
  endtask

  // drives the beats of pkt[]; the last beat is left on the bus
  task automatic stream_pkt(input logic tcp, input int ofs, input int l4len,
                            input logic csum, input bit gap, input bit garble,
                            input bit skip_first);
    for (int i = 0; i < pkt_n; i++) begin
      if (!(skip_first && i == 0)) @(negedge clk);
      if (gap && i == 5) begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b1; in_byte = 8'hEE;
        @(negedge clk);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == pkt_n - 1);
      in_byte  = pkt[i];
      csum_ok  = (i == pkt_n - 1) ? csum : !csum;
      if (i == 0 || !garble) begin
        is_tcp = tcp; l4_offset = 8'(ofs); l4_len = 16'(l4len);
      end else begin
        is_tcp = !tcp; l4_offset = 8'(ofs + 3); l4_len = 16'hFFFF;
      end
    end
  endtask

  task automatic expect_result(input int exp, input string req);
    @(negedge clk);
    go_idle();
    check({req, " strobe"}, int'(err_valid), 1);
    check({req, " code"}, int'(err_code), exp);
    @(negedge clk);
    check({req, " strobe one cycle"}, int'(err_valid), 0);
    check({req, " code idle"}, int'(err_code), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset valid", int'(err_valid), 0);
    check("R1 reset code", int'(err_code), 0);
  endtask

  task automatic t_clean();
    build_tcp(14, 1234, 80, 8'h10, 6);
    stream_pkt(1'b1, 14, 26, 1'b1, 0, 0, 0);
    expect_result(0, "R2 clean tcp");
    build_udp(34, 53, 4000, 12, 4, 8'h44);
    stream_pkt(1'b0, 34, 12, 1'b1, 0, 0, 0);
    expect_result(0, "R2 clean udp");
    build_tcp(14, 1234, 80, 8'h18, 3);
    stream_pkt(1'b1, 14, 23, 1'b1, 1, 0, 0);
    expect_result(0, "R2 gap in packet");
  endtask

  task automatic t_short();
    build_tcp(14, 1234, 80, 8'h10, 0);
    pkt_n = 14 + 19;
    stream_pkt(1'b1, 14, 19, 1'b1, 0, 0, 0);
    expect_result(1, "R3 tcp 19 bytes");
    build_tcp(14, 1234, 80, 8'h10, 0);
    stream_pkt(1'b1, 14, 20, 1'b1, 0, 0, 0);
    expect_result(0, "R3 tcp exactly 20 bytes");
    build_udp(20, 7, 9, 7, 0, 8'h0);
    pkt_n = 20 + 7;
    stream_pkt(1'b0, 20, 7, 1'b1, 0, 0, 0);
    expect_result(1, "R3 udp 7 bytes");
    pkt[0] = 8'h00; pkt_n = 1;
    stream_pkt(1'b0, 0, 1, 1'b0, 0, 0, 0);
    expect_result(1, "R3 one byte packet");
  endtask

  task automatic t_csum();
    build_tcp(14, 1234, 80, 8'h10, 2);
    stream_pkt(1'b1, 14, 22, 1'b0, 0, 0, 0);
    expect_result(2, "R4 tcp checksum bad");
    build_udp(14, 1, 2, 8, 0, 8'h0);
    stream_pkt(1'b0, 14, 8, 1'b0, 0, 0, 0);
    expect_result(2, "R4 udp checksum bad");
  endtask

  task automatic t_len();
    build_tcp(14, 1234, 80, 8'h10, 6);
    stream_pkt(1'b1, 14, 30, 1'b1, 0, 0, 0);
    expect_result(3, "R5 tcp length mismatch");
    build_udp(14, 1, 2, 12, 4, 8'h66);
    stream_pkt(1'b0, 14, 14, 1'b1, 0, 0, 0);
    expect_result(3, "R5 udp field mismatch");
  endtask

  task automatic t_port();
    build_tcp(14, 0, 80, 8'h10, 0);
    stream_pkt(1'b1, 14, 20, 1'b1, 0, 0, 0);
    expect_result(4, "R6 tcp source port zero");
    build_udp(14, 99, 0, 8, 0, 8'h0);
    stream_pkt(1'b0, 14, 8, 1'b1, 0, 0, 0);
    expect_result(4, "R6 udp destination port zero");
  endtask

  task automatic flag_case(input logic [7:0] f, input int exp, input string req);
    build_tcp(14, 1000, 2000, f, 0);
    stream_pkt(1'b1, 14, 20, 1'b1, 0, 0, 0);
    expect_result(exp, req);
  endtask

  task automatic t_flags();
    flag_case(8'h01, 8,  "R7 FIN alone");
    flag_case(8'h00, 9,  "R7 no flags");
    flag_case(8'h11, 0,  "R8 FIN ACK legal");
    flag_case(8'h15, 10, "R8 FIN RST");
    flag_case(8'h22, 11, "R8 SYN URG");
    flag_case(8'h16, 12, "R8 SYN RST");
    flag_case(8'h03, 13, "R8 SYN FIN");
    flag_case(8'h12, 0,  "R8 SYN ACK legal");
  endtask

  task automatic t_priority();
    flag_case(8'h07, 10, "R9 SYN FIN RST lowest flag code");
    flag_case(8'h23, 11, "R9 SYN URG FIN lowest flag code");
    build_tcp(14, 0, 0, 8'h00, 2);
    stream_pkt(1'b1, 14, 40, 1'b0, 0, 0, 0);
    expect_result(2, "R9 csum over len port flags");
    build_tcp(14, 0, 5, 8'h01, 2);
    stream_pkt(1'b1, 14, 40, 1'b1, 0, 0, 0);
    expect_result(3, "R9 len over port flags");
    build_tcp(14, 0, 0, 8'h00, 0);
    pkt_n = 14 + 15;
    stream_pkt(1'b1, 14, 99, 1'b0, 0, 0, 0);
    expect_result(1, "R9 malformed hides all");
  endtask

  task automatic t_udp_flags();
    build_udp(14, 10, 20, 16, 8, 8'h00);
    stream_pkt(1'b0, 14, 16, 1'b1, 0, 0, 0);
    expect_result(0, "R10 udp byte 13 zero ignored");
    build_udp(14, 10, 20, 16, 8, 8'h03);
    stream_pkt(1'b0, 14, 16, 1'b1, 0, 0, 0);
    expect_result(0, "R10 udp byte 13 SYN FIN ignored");
  endtask

  task automatic t_sideband();
    build_tcp(14, 1234, 80, 8'h10, 4);
    stream_pkt(1'b1, 14, 24, 1'b1, 0, 1, 0);
    expect_result(0, "R11 sideband changes after start ignored");
    // stray beats outside any packet
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_byte = 8'h00; csum_ok = 1'b0;
    @(negedge clk);
    go_idle();
    check("R11 stray end beat no strobe", int'(err_valid), 0);
    @(negedge clk);
    check("R11 stray end beat no strobe later", int'(err_valid), 0);
  endtask

  task automatic t_back_to_back();
    build_tcp(14, 1234, 80, 8'h01, 0);
    stream_pkt(1'b1, 14, 20, 1'b1, 0, 0, 0);
    @(negedge clk);
    check("R2 back-to-back first strobe", int'(err_valid), 1);
    check("R2 back-to-back first code", int'(err_code), 8);
    build_udp(0, 5, 6, 8, 0, 8'h0);
    stream_pkt(1'b0, 0, 8, 1'b1, 0, 0, 1);
    expect_result(0, "R2 back-to-back second packet");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_short();
    t_csum();
    t_len();
    t_port();
    t_flags();
    t_priority();
    t_udp_flags();
    t_sideband();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule